// File: doc/BRIEF.md
# Line-Delay FIFO Controller

This block sits in a raster video pipeline and steers a one-line delay buffer, so that each pixel of the current line comes out next to the pixel in the same column of the line before it. It takes a frame-valid strobe, a line-valid strobe and the pixel stream. It drives the buffer's write and read enables and presents the aligned pair with a qualifying strobe. The buffer is a plain internal array whose depth is a parameter, and which is written so that block RAM can be inferred.

After a reset the block stays idle until frame-valid has been seen low once. A stream that is picked up in the middle of a frame therefore never starts filling the buffer. The first line stored after reset is only written. Every later line reads one stored line out while it writes itself in, starting on the same line edge, so each stored line is read exactly once and the fill level stays at one line. A sticky flag reports a write that the buffer had no room for.

Top module: `line_delay_ctrl`

## Requirements
- R1: Reset is synchronous and active high and passes through one register first. The enables, pair strobe, pair data and overflow flag read zero from the second rising edge after `rst` is sampled high, and not before it.
- R2: After reset, no write or read enable is issued until `frame_valid` has been sampled low at least once.
- R3: Once armed, a rise of `line_valid` while `frame_valid` is high sets `wr_en` on the next clock edge. `wr_en` stays high for every cycle that `line_valid` stays high and drops on the edge after `line_valid` falls, so one write is made per pixel.
- R4: Pulses on `line_valid` while `frame_valid` is low cause no write and no read, and leave the stored line unchanged.
- R5: The first line stored after reset raises `wr_en` only. `rd_en` and `pair_valid` stay low for that line.
- R6: Every later line, including the first line of each new frame, raises `rd_en` in the same cycles as `wr_en`. Over a run of equal-length lines, the writes exceed the reads by exactly one line.
- R7: `pair_valid` rises one clock after `rd_en`. While it is high, `cur_pix` carries the pixel written in the cycle of that read and `dly_pix` carries the pixel from the same column of the previously stored line.
- R8: `overflow` is set, and stays set until reset, when a write arrives while the buffer holds `DEPTH` pixels and no read takes place in that cycle. A stored line of exactly `DEPTH` pixels does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset, registered inside |
| frame_valid | input | 1 | High while a frame is active |
| line_valid | input | 1 | High while the pixels of a line are present |
| pix_in | input | DATA_W | Incoming pixel |
| wr_en | output | 1 | Buffer write enable, registered |
| rd_en | output | 1 | Buffer read enable, registered |
| cur_pix | output | DATA_W | Current-line pixel, aligned with `dly_pix` |
| dly_pix | output | DATA_W | Same-column pixel of the previous stored line |
| pair_valid | output | 1 | The pair on `cur_pix`/`dly_pix` is valid |
| overflow | output | 1 | Sticky: a write found the buffer full |

## Verification
The assertions assume that `line_valid` rises and falls only while `frame_valid` is high, except for the deliberate stray pulses in the frame gaps. They also assume that all lines of one run have the same length and that this length is no greater than `DEPTH`. A read is then never made on an empty buffer, and every pair strobe traces back to a write. The stimulus keeps each line length fixed within a reset-bounded run and sweeps that length from 1 to the depth. It steps past these limits on purpose in only two places: the stray gap pulses, and one over-long first line, after which the design is reset.

// File: rtl/ldc_pkg.sv
package ldc_pkg;
  // Enable pair issued to the line buffer in one cycle
  typedef struct packed {
    logic wr;
    logic rd;
  } ldc_req_t;
endpackage

// File: rtl/ldc_reset_reg.sv
module ldc_reset_reg (
  input  logic clk,
  input  logic rst_in,
  output logic rst_out
);
  // Power-up value holds the block in reset until the first sample
  logic rst_q = 1'b1;

  always_ff @(posedge clk) begin
    rst_q <= rst_in;
  end

  assign rst_out = rst_q;
endmodule

// File: rtl/ldc_enable_gen.sv
module ldc_enable_gen
  import ldc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     frame_valid,
  input  logic     line_valid,
  output ldc_req_t req
);
  logic lv_d;       // line_valid one cycle ago, for edge detection
  logic armed;      // a frame gap has been observed since reset
  logic primed;     // at least one pixel has been written
  logic wr_q, rd_q;
  logic line_start;
  logic active;

  assign line_start = line_valid && !lv_d;
  assign active     = frame_valid && line_valid && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      lv_d   <= 1'b0;
      armed  <= 1'b0;
      primed <= 1'b0;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      lv_d   <= line_valid;
      armed  <= armed || !frame_valid;
      primed <= primed || wr_q;
      wr_q   <= active && (line_start || wr_q);
      rd_q   <= active && ((line_start && primed) || rd_q);
    end
  end

  assign req.wr = wr_q;
  assign req.rd = rd_q;

  // R3: a write cycle always follows a cycle with line_valid high
  assert_wr_needs_line_R3: assert property (@(posedge clk) disable iff (rst)
    req.wr |-> $past(line_valid));

  // R2: nothing is written before a frame gap has armed the block
  assert_unarmed_no_wr_R2: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !req.wr);

  // R5: no read before anything has been stored
  assert_first_line_no_rd_R5: assert property (@(posedge clk) disable iff (rst)
    !primed |=> !req.rd);

  // R6: reads only happen in write cycles
  assert_rd_within_wr_R6: assert property (@(posedge clk) disable iff (rst)
    req.rd |-> req.wr);
endmodule

// File: rtl/ldc_line_fifo.sv
module ldc_line_fifo
  import ldc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  ldc_req_t          req,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [CW-1:0]     count;
  logic              full, empty, do_wr, do_rd;

  assign full  = (count == FULL);
  assign empty = (count == '0);
  assign do_wr = req.wr && (!full || req.rd);
  assign do_rd = req.rd && !empty;

  // Storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wdata;
    if (do_rd) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (req.wr && full && !req.rd) overflow <= 1'b1;
    end
  end

  // R6: the enable generator never reads an empty buffer
  assert_read_not_empty_R6: assert property (@(posedge clk) disable iff (rst)
    req.rd |-> !empty);

  // R8: the fill level never exceeds the depth
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);
endmodule

// File: rtl/ldc_align.sv
module ldc_align #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [DATA_W-1:0] cur_in,
  output logic [DATA_W-1:0] cur_out,
  output logic              pair_valid
);
  // Delays the current pixel by the buffer's one-cycle read latency
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_out    <= '0;
      pair_valid <= 1'b0;
    end else begin
      cur_out    <= cur_in;
      pair_valid <= rd;
    end
  end
endmodule

// File: rtl/line_delay_ctrl.sv
module line_delay_ctrl
  import ldc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_valid,
  input  logic              line_valid,
  input  logic [DATA_W-1:0] pix_in,
  output logic              wr_en,
  output logic              rd_en,
  output logic [DATA_W-1:0] cur_pix,
  output logic [DATA_W-1:0] dly_pix,
  output logic              pair_valid,
  output logic              overflow
);
  logic              rst_q;
  ldc_req_t          req;
  logic [DATA_W-1:0] pix_q;
  logic [DATA_W-1:0] fifo_rdata;

  ldc_reset_reg u_rst (
    .clk     (clk),
    .rst_in  (rst),
    .rst_out (rst_q)
  );

  ldc_enable_gen u_en (
    .clk         (clk),
    .rst         (rst_q),
    .frame_valid (frame_valid),
    .line_valid  (line_valid),
    .req         (req)
  );

  // Pixel staged so it lines up with the registered write enable
  always_ff @(posedge clk) begin
    pix_q <= pix_in;
  end

  ldc_line_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst_q),
    .req      (req),
    .wdata    (pix_q),
    .rdata    (fifo_rdata),
    .overflow (overflow)
  );

  ldc_align #(.DATA_W(DATA_W)) u_align (
    .clk        (clk),
    .rst        (rst_q),
    .rd         (req.rd),
    .cur_in     (pix_q),
    .cur_out    (cur_pix),
    .pair_valid (pair_valid)
  );

  assign wr_en   = req.wr;
  assign rd_en   = req.rd;
  assign dly_pix = pair_valid ? fifo_rdata : '0;

  // R7: a valid pair always belongs to a cycle that also wrote
  assert_pair_after_write_R7: assert property (@(posedge clk) disable iff (rst_q)
    pair_valid |-> $past(wr_en));
endmodule

// File: tb/line_delay_ctrl_bench.sv
module line_delay_ctrl_bench;
  localparam int PERIOD = 10;
  localparam int DW     = 8;
  localparam int DEP    = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_valid = 1'b1;
  logic          line_valid  = 1'b0;
  logic [DW-1:0] pix_in = '0;
  logic          wr_en, rd_en, pair_valid, overflow;
  logic [DW-1:0] cur_pix, dly_pix;

  int compared = 0;
  int mismatched = 0;

  logic [DW-1:0] cap_cur [32];
  logic [DW-1:0] cap_dly [32];
  int cap_n = 0;
  int wr_total = 0;
  int rd_total = 0;

  // previously stored line
  int  prev_f, prev_ln, prev_len;
  bit  stored_any;

  always #(PERIOD/2) clk = ~clk;

  line_delay_ctrl #(.DATA_W(DW), .DEPTH(DEP)) u_line_delay_ctrl (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .line_valid(line_valid),
    .pix_in(pix_in), .wr_en(wr_en), .rd_en(rd_en), .cur_pix(cur_pix),
    .dly_pix(dly_pix), .pair_valid(pair_valid), .overflow(overflow)
  );

  always @(negedge clk) begin
    if (pair_valid && cap_n < 32) begin
      cap_cur[cap_n] = cur_pix;
      cap_dly[cap_n] = dly_pix;
      cap_n = cap_n + 1;
    end
    if (wr_en) wr_total = wr_total + 1;
    if (rd_en) rd_total = rd_total + 1;
  end

  function automatic logic [DW-1:0] pixv(input int f, input int ln, input int c);
    return DW'(f * 37 + ln * 11 + c * 3 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared = compared + 1;
    if (!ok) begin
      mismatched = mismatched + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_valid = 1'b0;
    end
  endtask

  task automatic do_reset(input bit fv);
    @(negedge clk);
    rst = 1'b1; frame_valid = fv; line_valid = 1'b0;
    idle(4);
    rst = 1'b0;
    stored_any = 0;
    idle(2);
  endtask

  // One line; checks enable timing per cycle and the pairs afterwards
  task automatic do_line(input int len, input bit expw, input int f, input int ln);
    bit expr;
    expr = expw && stored_any;
    cap_n = 0;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      if (c > 0) begin
        chk(wr_en == expw, "R3 wr_en during line", wr_en, expw);
        chk(rd_en == expr, expr ? "R6 rd_en with wr_en" : "R5 rd_en held low", rd_en, expr);
      end
      line_valid = 1'b1; pix_in = pixv(f, ln, c);
    end
    @(negedge clk);
    chk(wr_en == expw, "R3 wr_en last pixel", wr_en, expw);
    chk(rd_en == expr, "R6 rd_en last pixel", rd_en, expr);
    line_valid = 1'b0;
    @(negedge clk);
    chk(wr_en == 1'b0, "R3 wr_en drops after line", wr_en, 0);
    chk(rd_en == 1'b0, "R6 rd_en drops after line", rd_en, 0);
    idle(2);
    if (expr && len <= DEP) begin
      chk(cap_n == len, "R7 pair count", cap_n, len);
      for (int c = 0; c < len && c < cap_n; c++) begin
        chk(cap_cur[c] == pixv(f, ln, c), "R7 cur_pix", cap_cur[c], pixv(f, ln, c));
        chk(cap_dly[c] == pixv(prev_f, prev_ln, c), "R7 dly_pix", cap_dly[c],
            pixv(prev_f, prev_ln, c));
      end
    end else begin
      chk(cap_n == 0, expw ? "R5 no pair on first line" : "R2 no pair unarmed", cap_n, 0);
    end
    if (expw) begin
      stored_any = 1; prev_f = f; prev_ln = ln; prev_len = len;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    mismatched = mismatched + 1;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset(1'b1);
    chk(wr_en == 0 && rd_en == 0, "R1 enables at reset", {wr_en, rd_en}, 0);
    chk(pair_valid == 0 && overflow == 0, "R1 flags at reset", {pair_valid, overflow}, 0);
    chk(cur_pix == 0 && dly_pix == 0, "R1 pair data at reset", cur_pix, 0);

    // R2: frame_valid never low since reset, lines must not be stored
    for (int ln = 0; ln < 3; ln++) do_line(4, 1'b0, 0, ln);

    // Sweep line length over the whole depth
    for (int len = 1; len <= DEP; len++) begin
      do_reset(1'b1);
      wr_total = 0; rd_total = 0;
      for (int f = 1; f <= 3; f++) begin
        @(negedge clk); frame_valid = 1'b0;
        // R4: stray pulse in the gap
        @(negedge clk); line_valid = 1'b1; pix_in = 8'hEE;
        @(negedge clk); line_valid = 1'b0;
        @(negedge clk);
        chk(wr_en == 0 && rd_en == 0, "R4 gap pulse ignored", {wr_en, rd_en}, 0);
        idle(2);
        frame_valid = 1'b1;
        idle(1);
        for (int ln = 0; ln < 3; ln++) do_line(len, 1'b1, f + len * 4, ln);
      end
      chk(wr_total - rd_total == len, "R6 write/read balance", wr_total - rd_total, len);
      chk(overflow == 1'b0, "R8 no overflow at length <= depth", overflow, 0);
    end

    // R8: first line longer than the depth
    do_reset(1'b0);
    frame_valid = 1'b1;
    idle(1);
    do_line(DEP + 1, 1'b1, 50, 0);
    chk(overflow == 1'b1, "R8 overflow set", overflow, 1);
    idle(3);
    chk(overflow == 1'b1, "R8 overflow sticky", overflow, 1);

    // R1: reset takes effect on the second edge
    do_reset(1'b0);
    frame_valid = 1'b1;
    idle(1);
    @(negedge clk); line_valid = 1'b1; pix_in = 8'h11;
    @(negedge clk);
    chk(wr_en == 1'b1, "R1 wr_en before reset", wr_en, 1);
    rst = 1'b1;
    @(negedge clk);
    chk(wr_en == 1'b1, "R1 wr_en one edge after reset", wr_en, 1);
    @(negedge clk);
    chk(wr_en == 1'b0, "R1 wr_en cleared on second edge", wr_en, 0);
    chk(overflow == 1'b0, "R1 overflow cleared", overflow, 0);
    line_valid = 1'b0;
    rst = 1'b0;
    idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule